// File: doc/BRIEF.md
# Parallel Port ECP Host Register Front-End

This block sits between a host byte bus and the peripheral side of a parallel printer port running in the extended-capability and enhanced modes. It decodes single-byte reads and writes at two offsets. At offset 0 it behaves as a plain data register in the standard and bidirectional modes. In the extended-capability mode it becomes a write-only channel that places command-tagged bytes into a shared 9-bit FIFO. At offset 1 it presents a read-only status byte built from the printer handshake lines.

The port mode field and the direction bit come from elsewhere and arrive as inputs. The FIFO read side is exposed so that the peripheral handshake engine can drain it. The block also contains the enhanced-mode time-out logic. A bus cycle that stays incomplete for a set number of clocks raises a sticky flag. A status read clears that flag, and entering the enhanced mode clears it as well.

Top module: `ppt_ecp_regs`

## Requirements
- R1: A read at offset 0 with the mode field at 3'b000 or 3'b001 returns the live value of `pd_pins_i` in the same cycle, not the last written byte.
- R2: A write at offset 0 with the mode field at 3'b000 or 3'b001 loads `pd_latch_o` on that clock edge. After reset `pd_latch_o` is 0.
- R3: A write at offset 0 with the mode field at 3'b011 and `dir_rev_i` = 0 pushes one FIFO entry with bit 8 = 1 (command tag) and bits 7:0 = the written byte. Entries leave the FIFO in push order.
- R4: A write at offset 0 with the mode field at 3'b011 and `dir_rev_i` = 1 is discarded, and the FIFO level does not change.
- R5: A read at offset 0 with the mode field at 3'b011 returns 8'h00.
- R6: A read at offset 1 returns bit 7 = NOT `busy_i`, bit 6 = `ack_i`, bit 5 = `pe_i`, bit 4 = `slct_i`, bit 3 = `err_i`, and bits 2:1 = 2'b11.
- R7: Writes at offset 1 change neither the status value nor `pd_latch_o`.
- R8: When the mode field is not 3'b100 (the enhanced mode), status bit 0 reads as 1.
- R9: In the enhanced mode, status bit 0 shows the time-out flag. The flag is cleared on the first clock in the enhanced mode and is cleared again by a status read.
- R10: The flag sets when `epp_cyc_i` stays high in the enhanced mode for `TMO_CYCLES` consecutive clocks. A shorter high period leaves the flag clear.
- R11: When the time-out event and a status read fall in the same cycle, the flag ends up set.
- R12: The FIFO holds `FIFO_DEPTH` entries. A push while full is dropped and sets `fifo_ovf_o`, which stays set until reset. After reset the FIFO is empty and `fifo_ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one byte per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Register offset (0 or 1) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational on the access |
| mode_i | input | 3 | Port mode field |
| dir_rev_i | input | 1 | Direction bit, 1 = reverse |
| pd_pins_i | input | 8 | Live data pin values |
| pd_latch_o | output | 8 | Latched data byte for the pin drivers |
| busy_i | input | 1 | Printer busy line |
| ack_i | input | 1 | Acknowledge line |
| pe_i | input | 1 | Paper-end line |
| slct_i | input | 1 | Select line |
| err_i | input | 1 | Error line |
| epp_cyc_i | input | 1 | Enhanced-mode bus cycle in progress |
| fifo_pop_i | input | 1 | Pop the FIFO head |
| fifo_head_o | output | 9 | FIFO head {tag, byte} |
| fifo_level_o | output | 5 | Entries held |
| fifo_full_o | output | 1 | FIFO full |
| fifo_empty_o | output | 1 | FIFO empty |
| fifo_ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `mode_i` and `dir_rev_i` stay constant during any single access. They also assume that `fifo_pop_i` is only raised by the drain side, never in a cycle where the property itself counts a push. The level properties therefore exempt cycles with a pop. The stimulus changes the mode and direction only in idle cycles. It drains the FIFO only from a monitor that runs while the driver is not pushing. Time-out runs hold `epp_cyc_i` steady for exact clock counts, so each event lands in a known cycle.

// File: rtl/ppt_ecp_pkg.sv
package ppt_ecp_pkg;

    typedef enum logic [2:0] {
        MODE_STD   = 3'b000,
        MODE_BIDIR = 3'b001,
        MODE_FIFO  = 3'b010,
        MODE_ECP   = 3'b011,
        MODE_EPP   = 3'b100,
        MODE_RSV   = 3'b101,
        MODE_TEST  = 3'b110,
        MODE_CFG   = 3'b111
    } pmode_e;

    typedef struct packed {
        logic       cmd;
        logic [7:0] val;
    } fentry_t;

    typedef struct packed {
        logic dat_wr;
        logic dat_rd;
        logic adr_push;
        logic sts_rd;
    } acc_t;

    function automatic logic mode_is_epp(input logic [2:0] m);
        return m == MODE_EPP;
    endfunction

    function automatic logic mode_is_plain(input logic [2:0] m);
        return (m == MODE_STD) || (m == MODE_BIDIR);
    endfunction

    function automatic logic [7:0] pack_status(input logic busy, input logic ack,
                                               input logic pe, input logic slct,
                                               input logic err, input logic tbit);
        return {~busy, ack, pe, slct, err, 2'b11, tbit};
    endfunction

endpackage

// File: rtl/ppt_ecp_decode.sv
module ppt_ecp_decode
    import ppt_ecp_pkg::*;
(
    input  logic       sel,
    input  logic       wr,
    input  logic       addr,
    input  logic [2:0] mode,
    input  logic       dir_rev,
    output acc_t       acc
);
    logic plain, ecp, off0, off1;

    always_comb begin
        plain        = mode_is_plain(mode);
        ecp          = (mode == MODE_ECP);
        off0         = sel && !addr;
        off1         = sel && addr;
        acc.dat_wr   = off0 && wr && plain;
        acc.dat_rd   = off0 && !wr && plain;
        acc.adr_push = off0 && wr && ecp && !dir_rev;
        acc.sts_rd   = off1 && !wr;
    end
endmodule

// File: rtl/ppt_ecp_fifo.sv
module ppt_ecp_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 9,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          ovf
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (cnt == CW'(DEPTH));
        empty   = (cnt == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        head    = mem[rp];
        level   = cnt;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (push_ok) wp <= nxt(wp);
            if (pop_ok)  rp <= nxt(rp);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/ppt_ecp_tmo.sv
module ppt_ecp_tmo #(
    parameter int LIMIT = 1250,
    localparam int TW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic epp_mode,
    input  logic cyc_busy,
    input  logic sts_rd,
    output logic flag
);
    logic [TW-1:0] cnt;
    logic          prev_epp;
    logic          run, evt, entry;

    always_comb begin
        run   = epp_mode && cyc_busy;
        evt   = run && (cnt == TW'(LIMIT - 1));
        entry = epp_mode && !prev_epp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != TW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_epp <= 1'b0;
            flag     <= 1'b0;
        end else begin
            prev_epp <= epp_mode;
            if (evt)                       flag <= 1'b1;
            else if (entry)                flag <= 1'b0;
            else if (sts_rd && epp_mode)   flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ppt_ecp_regs.sv
module ppt_ecp_regs
    import ppt_ecp_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TMO_CYCLES = 1250,
    localparam int LW        = $clog2(FIFO_DEPTH + 1),
    localparam int EW        = $bits(fentry_t)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [2:0]    mode_i,
    input  logic          dir_rev_i,
    input  logic [7:0]    pd_pins_i,
    output logic [7:0]    pd_latch_o,
    input  logic          busy_i,
    input  logic          ack_i,
    input  logic          pe_i,
    input  logic          slct_i,
    input  logic          err_i,
    input  logic          epp_cyc_i,
    input  logic          fifo_pop_i,
    output logic [EW-1:0] fifo_head_o,
    output logic [LW-1:0] fifo_level_o,
    output logic          fifo_full_o,
    output logic          fifo_empty_o,
    output logic          fifo_ovf_o
);
    acc_t    acc;
    fentry_t in_ent;
    logic    tmo_flag;
    logic    epp_now;

    ppt_ecp_decode u_dec (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .mode    (mode_i),
        .dir_rev (dir_rev_i),
        .acc     (acc)
    );

    always_comb begin
        in_ent.cmd = 1'b1;
        in_ent.val = bus_wdata;
        epp_now    = mode_is_epp(mode_i);
    end

    ppt_ecp_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (acc.adr_push),
        .din   (in_ent),
        .pop   (fifo_pop_i),
        .head  (fifo_head_o),
        .level (fifo_level_o),
        .full  (fifo_full_o),
        .empty (fifo_empty_o),
        .ovf   (fifo_ovf_o)
    );

    ppt_ecp_tmo #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .epp_mode (epp_now),
        .cyc_busy (epp_cyc_i),
        .sts_rd   (acc.sts_rd),
        .flag     (tmo_flag)
    );

    always_ff @(posedge clk) begin
        if (rst)             pd_latch_o <= '0;
        else if (acc.dat_wr) pd_latch_o <= bus_wdata;
    end

    always_comb begin
        if (acc.dat_rd)
            bus_rdata = pd_pins_i;
        else if (acc.sts_rd)
            bus_rdata = pack_status(busy_i, ack_i, pe_i, slct_i, err_i,
                                    epp_now ? tmo_flag : 1'b1);
        else
            bus_rdata = 8'h00;
    end
endmodule

// File: rtl/ppt_ecp_regs_chk.sv
module ppt_ecp_regs_chk
    import ppt_ecp_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic          bus_addr,
    input logic [7:0]    bus_rdata,
    input logic [2:0]    mode_i,
    input logic          dir_rev_i,
    input logic [7:0]    pd_pins_i,
    input logic          busy_i,
    input logic          err_i,
    input logic          fifo_pop_i,
    input logic [LW-1:0] fifo_level_o,
    input logic          fifo_full_o,
    input logic          fifo_ovf_o
);
    logic ecp_wr0;
    always_comb ecp_wr0 = bus_sel && bus_wr && !bus_addr && (mode_i == MODE_ECP);

    // R1
    dat_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !bus_addr && (mode_i == MODE_STD || mode_i == MODE_BIDIR))
        |-> bus_rdata == pd_pins_i);

    // R6
    sts_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr)
        |-> (bus_rdata[2:1] == 2'b11 && bus_rdata[7] == !busy_i && bus_rdata[3] == err_i));

    // R8
    tbit_one_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr && mode_i != MODE_EPP) |-> bus_rdata[0]);

    // R3
    push_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        (ecp_wr0 && !dir_rev_i && !fifo_full_o && !fifo_pop_i)
        |=> fifo_level_o == LW'($past(fifo_level_o) + 1'b1));

    // R4
    rev_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ecp_wr0 && dir_rev_i && !fifo_pop_i) |=> $stable(fifo_level_o));

    // R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_ovf_o |=> fifo_ovf_o);

    // R12
    full_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_full_o |-> fifo_level_o == LW'(FIFO_DEPTH));
endmodule

bind ppt_ecp_regs ppt_ecp_regs_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .mode_i       (mode_i),
    .dir_rev_i    (dir_rev_i),
    .pd_pins_i    (pd_pins_i),
    .busy_i       (busy_i),
    .err_i        (err_i),
    .fifo_pop_i   (fifo_pop_i),
    .fifo_level_o (fifo_level_o),
    .fifo_full_o  (fifo_full_o),
    .fifo_ovf_o   (fifo_ovf_o)
);

// File: tb/sim_ppt_ecp_regs.sv
module sim_ppt_ecp_regs;
    localparam int DEPTH = 16;
    localparam int TMO   = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] mode_i = 3'b000;
    logic       dir_rev_i = 1'b0;
    logic [7:0] pd_pins_i = '0;
    logic [7:0] pd_latch_o;
    logic       busy_i = 1'b0, ack_i = 1'b1, pe_i = 1'b0, slct_i = 1'b0, err_i = 1'b1;
    logic       epp_cyc_i = 1'b0;
    logic       fifo_pop_i = 1'b0;
    logic [8:0] fifo_head_o;
    logic [4:0] fifo_level_o;
    logic       fifo_full_o, fifo_empty_o, fifo_ovf_o;

    int total = 0;
    int bad   = 0;
    logic [8:0] expq[$];
    bit drain = 1'b0;
    logic [7:0] rd;

    always #4 clk = ~clk;

    ppt_ecp_regs #(.FIFO_DEPTH(DEPTH), .TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_i(mode_i), .dir_rev_i(dir_rev_i),
        .pd_pins_i(pd_pins_i), .pd_latch_o(pd_latch_o), .busy_i(busy_i), .ack_i(ack_i),
        .pe_i(pe_i), .slct_i(slct_i), .err_i(err_i), .epp_cyc_i(epp_cyc_i),
        .fifo_pop_i(fifo_pop_i), .fifo_head_o(fifo_head_o), .fifo_level_o(fifo_level_o),
        .fifo_full_o(fifo_full_o), .fifo_empty_o(fifo_empty_o), .fifo_ovf_o(fifo_ovf_o)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_sts(input logic tb);
        return {~busy_i, ack_i, pe_i, slct_i, err_i, 1'b1, 1'b1, tb};
    endfunction

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    // driver: address write, model of the expected FIFO content
    task automatic ecp_push(input logic [7:0] d);
        if (mode_i == 3'b011 && !dir_rev_i && expq.size() < DEPTH)
            expq.push_back({1'b1, d});
        bus_write(1'b0, d);
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode_i = m;
        @(posedge clk);
    endtask

    task automatic drain_all();
        drain = 1'b1;
        for (int i = 0; i < 100 && expq.size() != 0; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        drain = 1'b0;
        chk(expq.size() == 0 && fifo_empty_o, "R3 drain", {11'b0, fifo_level_o}, 16'h0);
    endtask

    // monitor: compares every FIFO head that leaves against the queue
    always @(negedge clk) begin
        if (drain && !fifo_empty_o) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4 unexpected entry", {7'b0, fifo_head_o}, 16'h0);
            end else begin
                chk(fifo_head_o == expq[0], "R3 order/tag", {7'b0, fifo_head_o}, {7'b0, expq[0]});
                void'(expq.pop_front());
            end
            fifo_pop_i = 1'b1;
        end else begin
            fifo_pop_i = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 16'h0, 16'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R12 reset state, R2 reset latch
        chk(fifo_empty_o && fifo_level_o == 0, "R12 reset level", {11'b0, fifo_level_o}, 16'h0);
        chk(!fifo_ovf_o, "R12 reset ovf", {15'b0, fifo_ovf_o}, 16'h0);
        chk(pd_latch_o == 8'h00, "R2 reset latch", {8'b0, pd_latch_o}, 16'h0);

        // R1 live pins in both plain modes
        pd_pins_i = 8'hA5;
        bus_read(1'b0, rd);
        chk(rd == 8'hA5, "R1 std", {8'b0, rd}, 16'h00A5);
        set_mode(3'b001);
        pd_pins_i = 8'h3C;
        bus_read(1'b0, rd);
        chk(rd == 8'h3C, "R1 bidir", {8'b0, rd}, 16'h003C);

        // R2 latch then R1 read still shows pins
        bus_write(1'b0, 8'h5A);
        @(negedge clk);
        chk(pd_latch_o == 8'h5A, "R2 latch", {8'b0, pd_latch_o}, 16'h005A);
        pd_pins_i = 8'h0F;
        bus_read(1'b0, rd);
        chk(rd == 8'h0F, "R1 not latch", {8'b0, rd}, 16'h000F);

        // R6 / R8 status patterns
        set_mode(3'b000);
        busy_i = 1'b1; ack_i = 1'b0; pe_i = 1'b1; slct_i = 1'b0; err_i = 1'b1;
        bus_read(1'b1, rd);
        chk(rd == exp_sts(1'b1) && rd == 8'h2F, "R6 pat A", {8'b0, rd}, 16'h002F);
        busy_i = 1'b0; ack_i = 1'b1; pe_i = 1'b0; slct_i = 1'b1; err_i = 1'b0;
        bus_read(1'b1, rd);
        chk(rd == 8'hD7, "R6 pat B", {8'b0, rd}, 16'h00D7);
        chk(rd[0] == 1'b1, "R8 non-epp bit0", {15'b0, rd[0]}, 16'h1);

        // R7 status writes ignored
        bus_write(1'b1, 8'h00);
        bus_read(1'b1, rd);
        chk(rd == 8'hD7, "R7 status after write", {8'b0, rd}, 16'h00D7);
        chk(pd_latch_o == 8'h5A, "R7 latch untouched", {8'b0, pd_latch_o}, 16'h005A);

        // R3 forward pushes, R5 read zero
        set_mode(3'b011);
        ecp_push(8'h11); ecp_push(8'h22); ecp_push(8'h33);
        @(negedge clk);
        chk(fifo_level_o == 3, "R3 level", {11'b0, fifo_level_o}, 16'h3);
        bus_read(1'b0, rd);
        chk(rd == 8'h00, "R5 ecp read", {8'b0, rd}, 16'h0);
        drain_all();

        // R4 reverse write dropped
        @(negedge clk) dir_rev_i = 1'b1;
        ecp_push(8'h99);
        @(negedge clk);
        chk(fifo_level_o == 0 && fifo_empty_o, "R4 reverse", {11'b0, fifo_level_o}, 16'h0);
        @(negedge clk) dir_rev_i = 1'b0;

        // R12 overflow
        for (int i = 0; i < DEPTH + 1; i++) ecp_push(8'(i * 7 + 1));
        @(negedge clk);
        chk(fifo_level_o == DEPTH && fifo_full_o, "R12 full", {11'b0, fifo_level_o}, 16'(DEPTH));
        chk(fifo_ovf_o, "R12 ovf set", {15'b0, fifo_ovf_o}, 16'h1);
        drain_all();
        chk(fifo_ovf_o, "R12 ovf sticky", {15'b0, fifo_ovf_o}, 16'h1);

        // R9 entering EPP: flag clear
        set_mode(3'b100);
        bus_read(1'b1, rd);
        chk(rd[0] == 1'b0, "R9 entry clear", {15'b0, rd[0]}, 16'h0);

        // R10 full-length cycle sets flag
        @(negedge clk) epp_cyc_i = 1'b1;
        repeat (TMO) @(posedge clk);
        @(negedge clk) epp_cyc_i = 1'b0;
        bus_read(1'b1, rd);
        chk(rd[0] == 1'b1, "R10 timeout set", {15'b0, rd[0]}, 16'h1);
        bus_read(1'b1, rd);
        chk(rd[0] == 1'b0, "R9 read clears", {15'b0, rd[0]}, 16'h0);

        // R10 short cycle does not set
        @(negedge clk) epp_cyc_i = 1'b1;
        repeat (TMO - 2) @(posedge clk);
        @(negedge clk) epp_cyc_i = 1'b0;
        bus_read(1'b1, rd);
        chk(rd[0] == 1'b0, "R10 short no set", {15'b0, rd[0]}, 16'h0);

        // R9 re-entry clears a set flag, R8 shows 1 while outside
        @(negedge clk) epp_cyc_i = 1'b1;
        repeat (TMO) @(posedge clk);
        @(negedge clk) epp_cyc_i = 1'b0;
        set_mode(3'b000);
        bus_read(1'b1, rd);
        chk(rd[0] == 1'b1, "R8 outside epp", {15'b0, rd[0]}, 16'h1);
        set_mode(3'b100);
        bus_read(1'b1, rd);
        chk(rd[0] == 1'b0, "R9 reentry clear", {15'b0, rd[0]}, 16'h0);

        // R11 read in the event cycle: set wins
        @(negedge clk) epp_cyc_i = 1'b1;
        repeat (TMO - 1) @(posedge clk);
        bus_read(1'b1, rd);
        chk(rd[0] == 1'b0, "R11 same-cycle read value", {15'b0, rd[0]}, 16'h0);
        @(negedge clk) epp_cyc_i = 1'b0;
        bus_read(1'b1, rd);
        chk(rd[0] == 1'b1, "R11 set wins", {15'b0, rd[0]}, 16'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule